// File: doc/BRIEF.md
# Ternary CAM Search Engine with Lowest-Address Priority

This block is a small ternary content-addressable memory. Every entry holds a data word, a per-bit "don't care" mask and an occupancy flag kept in bit 0 of the stored entry word. A search compares a key against every occupied entry at once. It reports whether any entry hit, whether more than one hit, and the lowest hitting address, all qualified by a one-cycle result strobe.

Entries are written at a given address, cleared at a given address, or written to the lowest free slot. The last form is refused when the table is full. The array is split into four equal sections, and a 4-bit enable input picks which sections a search may hit. A configuration input overrides that gating. A global mask register removes chosen key bits from every compare, which narrows a search to a sub-field.

A three-state controller sequences each search. ST_IDLE accepts operations. A search moves it to ST_MATCH, which registers the hit vector. ST_MATCH always moves to ST_ENCODE, which registers the priority-encoded result. ST_ENCODE always returns to ST_IDLE. Operations presented outside ST_IDLE are dropped.

Top module: `tcam_search`

## Requirements
- R1: After reset no entry is occupied, `full` is 0, the global mask is 0, and `res_valid`, `res_hit`, `res_multi` and `res_addr` are 0.
- R2: An occupied entry hits when, for every key bit, the entry mask bit is 1, or the global mask bit is 1, or the stored data bit equals the key bit. Unoccupied entries never hit.
- R3: When several entries hit, `res_addr` is the lowest hitting address.
- R4: `res_multi` is 1 exactly when two or more entries hit. It is never 1 without `res_hit`.
- R5: `res_valid` is a single-cycle pulse that rises after the second clock edge following the edge that samples a search. `res_hit`, `res_multi` and `res_addr` are 0 whenever `res_valid` is 0.
- R6: Entry i belongs to section i/(DEPTH/4). It can hit only when `sect_en[section]` is 1. `sect_en` is sampled with the search.
- R7: When `sect_all` is 1 at search issue, all sections are searched regardless of `sect_en`.
- R8: Op code 4 loads `op_data` into the global mask register. A mask bit of 1 excludes that key bit from every compare.
- R9: Op code 0 stores `op_data` and `op_mask` at `op_addr` and sets its occupancy bit. Op code 1 clears the occupancy bit at `op_addr`. Op code 2 is a search with key `op_data`. Codes 5 to 7 do nothing.
- R10: Op code 3 stores `op_data` and `op_mask` in the lowest unoccupied entry and marks it occupied. `full` is 1 exactly when every entry is occupied. The op is refused while `full` is 1. `full` changes only after an edge that sampled `op_valid`.
- R11: Operations sampled while a search is in progress (ST_MATCH or ST_ENCODE) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation code (see R9, R10, R8) |
| op_addr | input | AW | Entry address for write and clear |
| op_data | input | KEY_W | Data, search key or global mask value |
| op_mask | input | KEY_W | Per-bit don't-care mask for writes |
| sect_en | input | 4 | Section enables for a search |
| sect_all | input | 1 | Search all sections, ignoring `sect_en` |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | At least one entry hit |
| res_multi | output | 1 | Two or more entries hit |
| res_addr | output | AW | Lowest hitting address |
| full | output | 1 | No unoccupied entry remains |

## Verification
A corrupted stored bit or occupancy flag shows on the next search that covers that entry, and it shows as a wrong hit, a wrong lowest address or a wrong multi flag. Occupancy damage also moves `full` and the target of the next lowest-free write. A controller that strays from its state sequence moves or repeats the result strobe. Any such fault is visible three clock edges after the search is issued. A stale global mask or section snapshot widens or narrows the set of hits in that same result. The bench sweeps every key of the small default configuration and every section-enable pattern, so each of these faults reaches a port within one sweep.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MATCH  = 2'd1,
        ST_ENCODE = 2'd2
    } state_e;

    localparam logic [2:0] OPC_WRITE  = 3'd0;
    localparam logic [2:0] OPC_ERASE  = 3'd1;
    localparam logic [2:0] OPC_SEARCH = 3'd2;
    localparam logic [2:0] OPC_WFREE  = 3'd3;
    localparam logic [2:0] OPC_GMASK  = 3'd4;
endpackage

// File: rtl/tcam_prio.sv
// Lowest-index priority encoder with "any" and "more than one" flags.
module tcam_prio #(
    parameter int N  = 16,
    localparam int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic          multi,
    output logic [AW-1:0] idx
);
    always_comb begin
        any   = 1'b0;
        multi = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) begin
                if (any) begin
                    multi = 1'b1;
                end else begin
                    idx = i[AW-1:0];
                end
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tcam_match.sv
// Parallel ternary compare of a key against every entry, with section gating.
module tcam_match #(
    parameter int KEY_W = 8,
    parameter int DEPTH = 16,
    parameter int NSEC  = 4,
    localparam int SEC_DEPTH = DEPTH / NSEC
) (
    input  logic [DEPTH-1:0][KEY_W-1:0] data_a,
    input  logic [DEPTH-1:0][KEY_W-1:0] mask_a,
    input  logic [DEPTH-1:0]            occ,
    input  logic [KEY_W-1:0]            key,
    input  logic [KEY_W-1:0]            gmask,
    input  logic [NSEC-1:0]             sec_on,
    output logic [DEPTH-1:0]            hit
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [KEY_W-1:0] diff;
        assign diff   = (data_a[i] ^ key) & ~(mask_a[i] | gmask);
        assign hit[i] = occ[i] & sec_on[i / SEC_DEPTH] & ~(|diff);
    end
endmodule

// File: rtl/tcam_search.sv
module tcam_search
    import tcam_pkg::*;
#(
    parameter int KEY_W = 8,
    parameter int DEPTH = 16,
    localparam int NSEC = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic [AW-1:0]    op_addr,
    input  logic [KEY_W-1:0] op_data,
    input  logic [KEY_W-1:0] op_mask,
    input  logic [NSEC-1:0]  sect_en,
    input  logic             sect_all,
    output logic             res_valid,
    output logic             res_hit,
    output logic             res_multi,
    output logic [AW-1:0]    res_addr,
    output logic             full
);
    state_e state_q, state_d;

    // Entry word: [KEY_W:1] data, [0] occupancy.
    logic [DEPTH-1:0][KEY_W:0]   ent_q;
    logic [DEPTH-1:0][KEY_W-1:0] mask_q;
    logic [KEY_W-1:0]            gmask_q;
    logic [KEY_W-1:0]            key_q;
    logic [NSEC-1:0]             sec_q;
    logic [DEPTH-1:0]            hit_q;

    logic [DEPTH-1:0][KEY_W-1:0] data_a;
    logic [DEPTH-1:0]            occ;
    logic [DEPTH-1:0]            hit;
    logic [DEPTH-1:0]            set_sel, clr_sel;
    logic                        free_any, free_multi_unused;
    logic [AW-1:0]               free_idx;
    logic                        p_any, p_multi;
    logic [AW-1:0]               p_idx;
    logic                        accept;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            occ[i]    = ent_q[i][0];
            data_a[i] = ent_q[i][KEY_W:1];
        end
    end

    tcam_match #(.KEY_W(KEY_W), .DEPTH(DEPTH), .NSEC(NSEC)) u_match (
        .data_a(data_a), .mask_a(mask_q), .occ(occ), .key(key_q),
        .gmask(gmask_q), .sec_on(sec_q), .hit(hit)
    );

    tcam_prio #(.N(DEPTH)) u_free (
        .vec(~occ), .any(free_any), .multi(free_multi_unused), .idx(free_idx)
    );

    tcam_prio #(.N(DEPTH)) u_res (
        .vec(hit_q), .any(p_any), .multi(p_multi), .idx(p_idx)
    );

    assign full   = ~free_any;
    assign accept = op_valid && (state_q == ST_IDLE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept && op_code == OPC_SEARCH) state_d = ST_MATCH;
            ST_MATCH:  state_d = ST_ENCODE;
            ST_ENCODE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Entry select decode
    always_comb begin
        set_sel = '0;
        clr_sel = '0;
        if (accept) begin
            case (op_code)
                OPC_WRITE: set_sel[op_addr] = 1'b1;
                OPC_ERASE: clr_sel[op_addr] = 1'b1;
                OPC_WFREE: if (free_any) set_sel[free_idx] = 1'b1;
                default:   ;
            endcase
        end
    end

    // Table storage and search pipeline registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q   <= '0;
            mask_q  <= '0;
            gmask_q <= '0;
            key_q   <= '0;
            sec_q   <= '0;
            hit_q   <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (set_sel[i]) begin
                    ent_q[i]  <= {op_data, 1'b1};
                    mask_q[i] <= op_mask;
                end else if (clr_sel[i]) begin
                    ent_q[i][0] <= 1'b0;
                end
            end
            if (accept && op_code == OPC_GMASK) gmask_q <= op_data;
            if (accept && op_code == OPC_SEARCH) begin
                key_q <= op_data;
                sec_q <= sect_all ? {NSEC{1'b1}} : sect_en;
            end
            if (state_q == ST_MATCH) hit_q <= hit;
        end
    end

    // Result outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_multi <= 1'b0;
            res_addr  <= '0;
        end else if (state_q == ST_ENCODE) begin
            res_valid <= 1'b1;
            res_hit   <= p_any;
            res_multi <= p_multi;
            res_addr  <= p_idx;
        end else begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_multi <= 1'b0;
            res_addr  <= '0;
        end
    end
endmodule

// File: rtl/tcam_search_chk.sv
module tcam_search_chk
    import tcam_pkg::*;
#(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic          res_valid,
    input logic          res_hit,
    input logic          res_multi,
    input logic [AW-1:0] res_addr,
    input logic          full,
    input state_e        st
);
    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_strobe_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(st) == ST_ENCODE);

    assert_quiet_outputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_hit && !res_multi && res_addr == '0));

    assert_multi_needs_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        res_multi |-> res_hit);

    assert_full_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(op_valid) |-> $stable(full));

    assert_busy_sequence_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MATCH) |=> (st == ST_ENCODE));
endmodule

bind tcam_search tcam_search_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .res_valid(res_valid),
    .res_hit(res_hit), .res_multi(res_multi), .res_addr(res_addr),
    .full(full), .st(state_q)
);

// File: tb/sim_tcam_search.sv
`timescale 1ns/1ps
module sim_tcam_search;
    localparam int KW = 8;
    localparam int D  = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [2:0]    op_code = '0;
    logic [AW-1:0] op_addr = '0;
    logic [KW-1:0] op_data = '0;
    logic [KW-1:0] op_mask = '0;
    logic [3:0]    sect_en = '0;
    logic          sect_all = 1'b0;
    logic          res_valid, res_hit, res_multi, full;
    logic [AW-1:0] res_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench reference state, built from the requirements
    logic [KW-1:0] md [D];
    logic [KW-1:0] mm [D];
    bit            mo [D];
    logic [KW-1:0] mg;

    always #10 clk = ~clk;

    tcam_search #(.KEY_W(KW), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_addr(op_addr), .op_data(op_data), .op_mask(op_mask),
        .sect_en(sect_en), .sect_all(sect_all), .res_valid(res_valid),
        .res_hit(res_hit), .res_multi(res_multi), .res_addr(res_addr), .full(full)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] c, input logic [AW-1:0] a,
                         input logic [KW-1:0] d, input logic [KW-1:0] m);
        @(negedge clk);
        op_valid = 1'b1; op_code = c; op_addr = a; op_data = d; op_mask = m;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic wr(input int a, input logic [KW-1:0] d, input logic [KW-1:0] m);
        issue(3'd0, a[AW-1:0], d, m);
        md[a] = d; mm[a] = m; mo[a] = 1;
    endtask

    task automatic er(input int a);
        issue(3'd1, a[AW-1:0], '0, '0);
        mo[a] = 0;
    endtask

    task automatic wf(input logic [KW-1:0] d, input logic [KW-1:0] m);
        int t = -1;
        for (int i = D - 1; i >= 0; i--) if (!mo[i]) t = i;
        issue(3'd3, '0, d, m);
        if (t >= 0) begin md[t] = d; mm[t] = m; mo[t] = 1; end
    endtask

    task automatic gmk(input logic [KW-1:0] g);
        issue(3'd4, '0, g, '0);
        mg = g;
    endtask

    task automatic search(input logic [KW-1:0] key, input logic [3:0] sen,
                          input bit all, input string req);
        int cnt = 0;
        int first = 0;
        for (int i = D - 1; i >= 0; i--) begin
            if (mo[i] && (all || sen[i / 4]) && (((md[i] ^ key) & ~(mm[i] | mg)) == 0)) begin
                cnt++;
                first = i;
            end
        end
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd2; op_data = key; sect_en = sen; sect_all = all;
        @(negedge clk);
        op_valid = 1'b0;
        chk(!res_valid, "R5 early strobe (1)", res_valid, 0);
        @(negedge clk);
        chk(!res_valid, "R5 early strobe (2)", res_valid, 0);
        @(negedge clk);
        chk(res_valid && res_hit == (cnt > 0) && res_multi == (cnt > 1)
            && (cnt == 0 ? res_addr == 0 : res_addr == first[AW-1:0]), req,
            {res_valid, res_hit, res_multi, res_addr},
            {1'b1, cnt > 0, cnt > 1, (cnt == 0) ? 4'd0 : first[AW-1:0]});
    endtask

    task automatic report;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        for (int i = 0; i < D; i++) begin md[i] = '0; mm[i] = '0; mo[i] = 0; end
        mg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!res_valid && !res_hit && !res_multi && res_addr == 0, "R1 outputs idle",
            {res_valid, res_hit, res_multi}, 0);
        chk(!full, "R1 full low", full, 0);
        search(8'h00, 4'hF, 1'b1, "R1 empty table has no hit");

        // R9, R2: exact entries, full key sweep
        for (int i = 0; i < D; i++) wr(i, i[KW-1:0], 8'h00);
        for (int k = 0; k < 256; k++) search(k[KW-1:0], 4'h0, 1'b1, "R2 R9 exact sweep");

        // R3, R4: overlapping ternary entries
        wr(1, 8'h00, 8'hFF);
        wr(12, 8'hA0, 8'h0F);
        for (int k = 0; k < 256; k++) search(k[KW-1:0], 4'hF, 1'b0, "R3 R4 overlap sweep");
        er(1);
        for (int k = 0; k < 256; k += 3) search(k[KW-1:0], 4'hF, 1'b0, "R9 erase sweep");

        // R6, R7: section gating, all entries wildcard
        for (int i = 0; i < D; i++) wr(i, 8'h00, 8'hFF);
        er(0); er(5); er(6); er(15);
        for (int s = 0; s < 16; s++) search(8'h5A, s[3:0], 1'b0, "R6 section sweep");
        for (int s = 0; s < 16; s++) search(8'h5A, s[3:0], 1'b1, "R7 sect_all override");

        // R8: global mask
        for (int i = 0; i < D; i++) wr(i, {i[3:0], i[3:0]}, 8'h00);
        gmk(8'hF0);
        for (int k = 0; k < 256; k++) search(k[KW-1:0], 4'hF, 1'b0, "R8 global mask F0");
        gmk(8'h0F);
        for (int k = 0; k < 256; k += 5) search(k[KW-1:0], 4'hF, 1'b0, "R8 global mask 0F");
        gmk(8'h00);

        // R10: lowest-free writes and full flag
        for (int i = 0; i < D; i++) er(i);
        chk(!full, "R10 full low when empty", full, 0);
        for (int k = 0; k < D; k++) begin
            wf(8'h20 + k[KW-1:0], 8'h00);
            chk(full == (k == D - 1), "R10 full after next-free write", full, (k == D - 1));
        end
        wf(8'h77, 8'h00);
        chk(full, "R10 full held after refused write", full, 1);
        search(8'h77, 4'hF, 1'b1, "R10 refused write not stored");
        er(7);
        chk(!full, "R10 full drops after erase", full, 0);
        wf(8'h99, 8'h00);
        search(8'h99, 4'hF, 1'b1, "R10 next-free lands on freed slot");
        chk(full, "R10 full again", full, 1);

        // R11: operations during a search are ignored
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd2; op_data = 8'h25; sect_all = 1'b1;
        @(negedge clk);
        op_code = 3'd0; op_addr = 4'd3; op_data = 8'hEE; op_mask = 8'h00;
        @(negedge clk);
        op_code = 3'd4; op_data = 8'hFF;
        @(negedge clk);
        op_valid = 1'b0;
        chk(res_valid && res_hit && res_addr == 4'd5, "R11 in-flight search result",
            {res_valid, res_hit, res_addr}, {1'b1, 1'b1, 4'd5});
        search(8'hEE, 4'hF, 1'b1, "R11 write during search ignored");
        search(8'h23, 4'hF, 1'b1, "R11 entry and global mask unchanged");

        // R9: unused op codes do nothing
        issue(3'd6, 4'd2, 8'h11, 8'hFF);
        search(8'h22, 4'hF, 1'b1, "R9 unused op code no effect");
        chk(full, "R9 unused op keeps full", full, 1);

        report();
    end
endmodule